// File: doc/BRIEF.md
# Translation Fault Capture and Interrupt Unit

Two address translation units each report faults to this block. A report is a vector of seven fault-type flags. With it come the faulting virtual address, the access direction, the page-table level, the offending physical address, and the requester identity (an arbiter number and a port number). The block keeps a combined 14-bit fault status word. For each unit it records the details of the first fault since the last clear, in read-only registers.

A 14-bit interrupt enable word selects which status bits may raise the single level interrupt. Software reads the status and detail registers through a simple register port. It then clears all status by writing a self-clearing bit in the control register, and that write also drops the interrupt.

Fault reports are single-cycle events with no back-pressure. The block takes a report on every clock edge where a type vector is nonzero. Register writes complete at the clock edge. Register reads are combinational from the address.

Top module: `fault_capture_irq`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: A unit-0 fault of type n (n = 0..6) sets status bit n, and a unit-1 fault of type n sets status bit n+7. The status word at offset 0x08 shows the bit after the clock edge that takes the event. Status bits only accumulate until a clear.
- R3: On the first fault of a unit, that unit's detail registers capture the report:
  - The address register holds va[31:2] with the write flag at bit 1 and the level flag at bit 0.
  - The physical register holds the full physical address.
  - The identity register holds the arbiter number in bits [9:7] and the port number in bits [6:2], with the other bits 0.
  - Unit 0 uses offsets 0x10, 0x14 and 0x18; unit 1 uses 0x20, 0x24 and 0x28.
- R4: While a unit's status field is nonzero, its detail registers keep their values, and later faults on that unit only OR new type bits into the status.
- R5: `irq_o` is high exactly when some status bit is set and the same bit of the enable register (offset 0x04, bits [13:0]) is set. It follows status and enable changes in the same cycle they become visible.
- R6: Writing control (offset 0x00) with bit 12 set clears the whole status word at that edge, so `irq_o` is low afterwards unless a fault arrives in the same cycle. Detail registers keep their last captured values, and bit 12 always reads 0.
- R7: A fault arriving in the same cycle as a clear wins: its type bits remain set, and its details are captured as a first fault.
- R8: Control bits 0, 1, 2, 3, 5 and 6 are read/write storage, and all other control bits read 0. Enable bits above 13 read 0, and unmapped offsets read 0.
- R9: Writes to the status and detail offsets have no effect.
- R10: Each unit freezes independently, so unit 1 captures its first fault while unit 0 is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 8 | Register byte offset (read and write) |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data for `csr_addr` |
| flt0_type | input | 7 | Unit 0 fault-type flags, nonzero marks an event |
| flt0_va | input | 32 | Unit 0 faulting virtual address |
| flt0_write | input | 1 | Unit 0 access was a write |
| flt0_layer | input | 1 | Unit 0 page-table level flag |
| flt0_pa | input | 32 | Unit 0 offending physical address |
| flt0_arb | input | 3 | Unit 0 requester arbiter number |
| flt0_port | input | 5 | Unit 0 requester port number |
| flt1_type | input | 7 | Unit 1 fault-type flags |
| flt1_va | input | 32 | Unit 1 faulting virtual address |
| flt1_write | input | 1 | Unit 1 access was a write |
| flt1_layer | input | 1 | Unit 1 page-table level flag |
| flt1_pa | input | 32 | Unit 1 offending physical address |
| flt1_arb | input | 3 | Unit 1 requester arbiter number |
| flt1_port | input | 5 | Unit 1 requester port number |
| irq_o | output | 1 | Level interrupt |

## Verification
Faults, enable writes and clears all take effect at the first rising edge after they are driven. Status, details and `irq_o` therefore reflect them one edge later, and reads are combinational with no added latency.

The bench drives inputs at the falling edge and lets one rising edge pass. It updates its model at that edge and compares `irq_o` shortly after it. It then reads back every register in later cycles with no events and no writes, so those reads cannot disturb state. Directed cases cover the freeze, masking, clear priority and write-ignore rules, and a seeded random stream checks the same model.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  localparam int NUM_UNITS  = 2;
  localparam int NUM_TYPES  = 7;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 8;
  localparam int ARB_W      = 3;
  localparam int PORT_W     = 5;
  localparam int STAT_W     = NUM_UNITS * NUM_TYPES;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_EN     = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h08;
  localparam int UNIT_BASE   = 16;
  localparam int UNIT_STRIDE = 16;
  localparam int OFS_VA = 0;
  localparam int OFS_PA = 4;
  localparam int OFS_ID = 8;

  localparam int CLR_BIT      = 12;
  localparam logic [DATA_W-1:0] CTRL_RW_MASK = 32'h0000_006F;
  localparam int ID_PORT_LSB  = 2;
  localparam int ID_ARB_LSB   = 7;

  typedef struct packed {
    logic [DATA_W-1:0] va;
    logic              wr;
    logic              layer;
    logic [DATA_W-1:0] pa;
    logic [ARB_W-1:0]  arb;
    logic [PORT_W-1:0] port;
  } fault_info_t;
endpackage

// File: rtl/fcu_capture.sv
module fcu_capture
  import fcu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_TYPES-1:0] evt_i,
  input  fault_info_t          info_i,
  input  logic                 clr_i,
  output logic [NUM_TYPES-1:0] status_o,
  output fault_info_t          info_o
);
  logic [NUM_TYPES-1:0] status_q;
  fault_info_t          info_q;
  logic                 take;

  // capture is open when nothing is latched or a clear lands this cycle
  assign take = (|evt_i) && ((status_q == '0) || clr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      info_q   <= '0;
    end else begin
      status_q <= (clr_i ? '0 : status_q) | evt_i;
      if (take) info_q <= info_i;
    end
  end

  assign status_o = status_q;
  assign info_o   = info_q;

  assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q != '0) && !clr_i) |=> $stable(info_q));

  assert_accumulate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_fault_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && (|evt_i)) |=> ((status_q == $past(evt_i)) && (info_q == $past(info_i))));
endmodule

// File: rtl/fcu_csr.sv
module fcu_csr
  import fcu_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  input  logic [STAT_W-1:0]               status_i,
  input  fault_info_t [NUM_UNITS-1:0]     info_i,
  output logic [STAT_W-1:0]               en_o,
  output logic                            clr_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic [STAT_W-1:0] en_q;

  assign clr_o = we_i && (addr_i == OFS_CTRL) && wdata_i[CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= '0;
    end else if (we_i) begin
      if (addr_i == OFS_CTRL) ctrl_q <= wdata_i & CTRL_RW_MASK;
      if (addr_i == OFS_EN)   en_q   <= wdata_i[STAT_W-1:0];
    end
  end

  assign en_o = en_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_CTRL)   rdata_o = ctrl_q;
    if (addr_i == OFS_EN)     rdata_o[STAT_W-1:0] = en_q;
    if (addr_i == OFS_STATUS) rdata_o[STAT_W-1:0] = status_i;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (addr_i == ADDR_W'(UNIT_BASE + u*UNIT_STRIDE + OFS_VA))
        rdata_o = {info_i[u].va[DATA_W-1:2], info_i[u].wr, info_i[u].layer};
      if (addr_i == ADDR_W'(UNIT_BASE + u*UNIT_STRIDE + OFS_PA))
        rdata_o = info_i[u].pa;
      if (addr_i == ADDR_W'(UNIT_BASE + u*UNIT_STRIDE + OFS_ID)) begin
        rdata_o[ID_ARB_LSB +: ARB_W]   = info_i[u].arb;
        rdata_o[ID_PORT_LSB +: PORT_W] = info_i[u].port;
      end
    end
  end

  assert_clear_bit_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == OFS_CTRL) |-> (rdata_o[CLR_BIT] == 1'b0));

  assert_ctrl_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == OFS_CTRL) |=> ((ctrl_q & ~CTRL_RW_MASK) == '0));
endmodule

// File: rtl/fault_capture_irq.sv
module fault_capture_irq
  import fcu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csr_we,
  input  logic [ADDR_W-1:0]    csr_addr,
  input  logic [DATA_W-1:0]    csr_wdata,
  output logic [DATA_W-1:0]    csr_rdata,
  input  logic [NUM_TYPES-1:0] flt0_type,
  input  logic [DATA_W-1:0]    flt0_va,
  input  logic                 flt0_write,
  input  logic                 flt0_layer,
  input  logic [DATA_W-1:0]    flt0_pa,
  input  logic [ARB_W-1:0]     flt0_arb,
  input  logic [PORT_W-1:0]    flt0_port,
  input  logic [NUM_TYPES-1:0] flt1_type,
  input  logic [DATA_W-1:0]    flt1_va,
  input  logic                 flt1_write,
  input  logic                 flt1_layer,
  input  logic [DATA_W-1:0]    flt1_pa,
  input  logic [ARB_W-1:0]     flt1_arb,
  input  logic [PORT_W-1:0]    flt1_port,
  output logic                 irq_o
);
  logic [NUM_UNITS-1:0][NUM_TYPES-1:0] evt;
  fault_info_t [NUM_UNITS-1:0]         info_in;
  fault_info_t [NUM_UNITS-1:0]         info_lat;
  logic [STAT_W-1:0]                   status;
  logic [STAT_W-1:0]                   en;
  logic                                clr;

  assign evt[0]     = flt0_type;
  assign evt[1]     = flt1_type;
  assign info_in[0] = '{va: flt0_va, wr: flt0_write, layer: flt0_layer,
                        pa: flt0_pa, arb: flt0_arb, port: flt0_port};
  assign info_in[1] = '{va: flt1_va, wr: flt1_write, layer: flt1_layer,
                        pa: flt1_pa, arb: flt1_arb, port: flt1_port};

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    fcu_capture u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_i    (evt[u]),
      .info_i   (info_in[u]),
      .clr_i    (clr),
      .status_o (status[u*NUM_TYPES +: NUM_TYPES]),
      .info_o   (info_lat[u])
    );
  end

  fcu_csr u_csr (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (csr_we),
    .addr_i  (csr_addr),
    .wdata_i (csr_wdata),
    .rdata_o (csr_rdata),
    .status_i(status),
    .info_i  (info_lat),
    .en_o    (en),
    .clr_o   (clr)
  );

  assign irq_o = |(status & en);

  assert_clear_drops_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (evt == '0)) |=> !irq_o);

  assert_event_sets_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(evt)) == $past(evt)));
endmodule

// File: tb/fault_capture_irq_bench.sv
`timescale 1ns/100ps
module fault_capture_irq_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, csr_we;
  logic [7:0]  csr_addr;
  logic [31:0] csr_wdata, csr_rdata;
  logic [6:0]  flt0_type, flt1_type;
  logic [31:0] flt0_va, flt0_pa, flt1_va, flt1_pa;
  logic        flt0_write, flt0_layer, flt1_write, flt1_layer;
  logic [2:0]  flt0_arb, flt1_arb;
  logic [4:0]  flt0_port, flt1_port;
  logic        irq_o;

  fault_capture_irq u_fault_capture_irq (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [13:0] m_st, m_en;
  logic [31:0] m_ctrl;
  logic [31:0] m_va [2];
  logic [31:0] m_pa [2];
  logic [31:0] m_id [2];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    case (a)
      8'h00: return m_ctrl;
      8'h04: return {18'b0, m_en};
      8'h08: return {18'b0, m_st};
      8'h10: return m_va[0];
      8'h14: return m_pa[0];
      8'h18: return m_id[0];
      8'h20: return m_va[1];
      8'h24: return m_pa[1];
      8'h28: return m_id[1];
      default: return 32'h0;
    endcase
  endfunction

  task automatic idle_inputs();
    csr_we = 0; csr_wdata = '0;
    flt0_type = '0; flt1_type = '0;
  endtask

  task automatic set_fault(input int u, input logic [6:0] t, input logic [31:0] va, input logic w,
                           input logic l, input logic [31:0] pa, input logic [2:0] arb, input logic [4:0] port);
    if (u == 0) begin
      flt0_type = t; flt0_va = va; flt0_write = w; flt0_layer = l;
      flt0_pa = pa; flt0_arb = arb; flt0_port = port;
    end else begin
      flt1_type = t; flt1_va = va; flt1_write = w; flt1_layer = l;
      flt1_pa = pa; flt1_arb = arb; flt1_port = port;
    end
  endtask

  // model of one clock edge, using the inputs driven since the last falling edge
  task automatic go();
    logic clr;
    logic [6:0] ev, st;
    @(posedge clk);
    clr = csr_we && csr_addr == 8'h00 && csr_wdata[12];
    for (int u = 0; u < 2; u++) begin
      ev = (u == 0) ? flt0_type : flt1_type;
      st = m_st[u*7 +: 7];
      if (ev != 0 && (st == 0 || clr)) begin
        m_va[u] = (u == 0) ? {flt0_va[31:2], flt0_write, flt0_layer} : {flt1_va[31:2], flt1_write, flt1_layer};
        m_pa[u] = (u == 0) ? flt0_pa : flt1_pa;
        m_id[u] = (u == 0) ? {22'b0, flt0_arb, flt0_port, 2'b00} : {22'b0, flt1_arb, flt1_port, 2'b00};
      end
      m_st[u*7 +: 7] = (clr ? 7'h0 : st) | ev;
    end
    if (csr_we && csr_addr == 8'h00) m_ctrl = csr_wdata & 32'h6F;
    if (csr_we && csr_addr == 8'h04) m_en = csr_wdata[13:0];
    #1;
    idle_inputs();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); csr_we = 1; csr_addr = a; csr_wdata = d; go();
  endtask

  task automatic chk_all(input string req);
    logic [7:0] addrs [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h28};
    @(negedge clk); #1;
    chk(req, "irq", {31'b0, irq_o}, {31'b0, |(m_st & m_en)});
    foreach (addrs[i]) begin
      @(negedge clk); idle_inputs(); csr_addr = addrs[i]; #1;
      chk(req, $sformatf("reg %h", addrs[i]), csr_rdata, model_rd(addrs[i]));
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    idle_inputs(); csr_addr = 0;
    set_fault(0, 0, 0, 0, 0, 0, 0, 0); set_fault(1, 0, 0, 0, 0, 0, 0, 0);
    rst_n = 0;
    m_st = 0; m_en = 0; m_ctrl = 0;
    for (int u = 0; u < 2; u++) begin m_va[u] = 0; m_pa[u] = 0; m_id[u] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk_all("R1");

    // R2 R3 R5: first fault on unit 0, all enabled
    wr(8'h04, 32'hFFFF_FFFF);
    @(negedge clk); set_fault(0, 7'b0001000, 32'hDEAD_BEEF, 1, 0, 32'h1234_5678, 3'd5, 5'd19); go();
    chk_all("R3");
    chk("R2", "status bit3", {18'b0, m_st}, 32'h8);
    // R4: later fault ORs type only
    @(negedge clk); set_fault(0, 7'b0000001, 32'h0BAD_F00D, 0, 1, 32'hCAFE_0000, 3'd1, 5'd2); go();
    chk_all("R4");
    // R10: unit 1 captures while unit 0 frozen
    @(negedge clk); set_fault(1, 7'b1000000, 32'h4444_0003, 0, 1, 32'h8888_0000, 3'd7, 5'd31); go();
    chk_all("R10");
    // R5: mask all -> irq low, status kept
    wr(8'h04, 32'h0);
    chk_all("R5");
    wr(8'h04, 32'h0000_2000);
    chk_all("R5");
    // R9: read-only offsets ignore writes
    wr(8'h08, 32'h0); wr(8'h10, 32'h0); wr(8'h14, 32'h0); wr(8'h28, 32'hFFFF_FFFF);
    chk_all("R9");
    // R8: control mask
    wr(8'h00, 32'hFFFF_EFFF);
    chk_all("R8");
    // R6: clear
    wr(8'h04, 32'h3FFF);
    wr(8'h00, 32'h0000_1003);
    chk_all("R6");
    chk("R6", "status cleared", {18'b0, m_st}, 32'h0);
    // R7: clear with simultaneous fault
    @(negedge clk); set_fault(1, 7'b0000100, 32'h1111_2222, 1, 1, 32'h3333_4444, 3'd2, 5'd7); go();
    @(negedge clk); csr_we = 1; csr_addr = 8'h00; csr_wdata = 32'h1000;
    set_fault(1, 7'b0010000, 32'h5555_6664, 0, 0, 32'h7777_8888, 3'd6, 5'd9); go();
    chk_all("R7");
    chk("R7", "status after tie", {18'b0, m_st}, 32'h0000_0800);

    // random phase
    for (int it = 0; it < 300; it++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0)
        set_fault(0, 7'($urandom), $urandom, 1'($urandom), 1'($urandom), $urandom, 3'($urandom), 5'($urandom));
      if ($urandom_range(3) == 0)
        set_fault(1, 7'($urandom), $urandom, 1'($urandom), 1'($urandom), $urandom, 3'($urandom), 5'($urandom));
      case ($urandom_range(7))
        0: begin csr_we = 1; csr_addr = 8'h00; csr_wdata = $urandom; end
        1: begin csr_we = 1; csr_addr = 8'h04; csr_wdata = $urandom; end
        2: begin csr_we = 1; csr_addr = 8'h08; csr_wdata = $urandom; end
        default: ;
      endcase
      go();
      if (it % 3 == 0) chk_all("R4");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule